// File: doc/BRIEF.md
# Flash Erase Unlock Controller

This block guards an on-chip flash array against accidental erasure. Software talks to it through a small byte-wide register write bus. An erase never follows from a single write. The register file must first be armed, and then a trigger register must receive a specific byte pattern. One pattern requests a whole-array (mass) erase and a different pattern requests a single-page erase. A mass erase is additionally refused unless the debug port is enabled.

The controller also holds a routing bit. This bit decides whether external-data store cycles land in flash or in data RAM. When an erase starts, the controller raises a one-cycle command pulse toward the flash array and holds a busy flag. Busy stays high until the array returns a done pulse. While busy is high, trigger writes are discarded.

Register addresses: trigger at 0x94; control at 0xB2 (bit 1 arms mass erase, bit 0 routes stores to flash); page register at 0xB7 (page number in bits [7:1]).

Top module: `flash_erase_guard`

## Requirements
- R1: After reset, both erase command outputs, `busy_o`, `store_to_flash_o` and `page_addr_o` are 0. Mass erase is not armed and no page is armed.
- R2: A write to address 0xB2 sets `store_to_flash_o` to data bit 0, visible in the cycle after the write. The same write loads the mass-erase arm flag from data bit 1.
- R3: When mass erase is armed and `dbg_en` is 1, a write of 0xAA to address 0x94 while idle makes `mass_erase_o` high for exactly the one cycle after the write. `busy_o` rises in that same cycle.
- R4: A 0xAA write to 0x94 starts no erase if mass erase is not armed or `dbg_en` is 0. In that case the arm flag keeps its value.
- R5: A write to 0xB7 puts data bits [7:1] on `page_addr_o` and arms a page erase. A later write of 0x55 to 0x94 while idle makes `page_erase_o` high for exactly one cycle and raises `busy_o`. A 0x55 write with no page armed does nothing.
- R6: While idle, a write to 0x94 of any value other than 0xAA or 0x55 starts nothing and clears the mass-erase arm flag.
- R7: Starting a mass erase clears the arm flag. Starting a page erase clears the page arm.
- R8: `busy_o` stays high from the command cycle until the cycle after `flash_done` is seen high. Writes to 0x94 while busy have no effect, including no disarming.
- R9: `mass_erase_o` and `page_erase_o` are never high together.
- R10: Writes to addresses other than 0x94, 0xB2 and 0xB7 change no output and no arm flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| dbg_en | input | 1 | Debug port enabled flag |
| flash_done | input | 1 | Pulse from flash array when an erase completes |
| mass_erase_o | output | 1 | One-cycle mass erase command |
| page_erase_o | output | 1 | One-cycle page erase command |
| page_addr_o | output | 7 | Page number for page erase |
| store_to_flash_o | output | 1 | 1 routes data store cycles to flash, 0 to data RAM |
| busy_o | output | 1 | Erase in progress |

## Verification
The hardest state to reach is a trigger write that arrives while busy and would disarm or start something if it were not discarded. The stimulus starts a page erase and, during busy, sends both a junk pattern and a full mass-erase trigger. After the done pulse it proves the arm flag survived by issuing a lone 0xAA. The main sweep also resets, arms in every combination, sends each of the 256 trigger values and then probes the hidden arm flag the same way. This shows whether each value disarmed, consumed or kept the mass-erase enable.

// File: rtl/flash_erase_guard.sv
module flash_erase_guard #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] ERASE_REG = 8'h94,
  parameter logic [AW-1:0] CTRL_REG  = 8'hB2,
  parameter logic [AW-1:0] PAGE_REG  = 8'hB7,
  parameter logic [DW-1:0] MASS_KEY  = 8'hAA,
  parameter logic [DW-1:0] PAGE_KEY  = 8'h55,
  parameter int ARM_BIT = 1,
  parameter int RTE_BIT = 0,
  localparam int PW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          dbg_en,
  input  logic          flash_done,
  output logic          mass_erase_o,
  output logic          page_erase_o,
  output logic [PW-1:0] page_addr_o,
  output logic          store_to_flash_o,
  output logic          busy_o
);

  logic          arm_q, pg_arm_q, rte_q, busy_q, mass_q, page_q;
  logic [PW-1:0] pg_q;

  wire trig_wr = reg_we && (reg_addr == ERASE_REG) && !busy_q;
  wire ctrl_wr = reg_we && (reg_addr == CTRL_REG);
  wire page_wr = reg_we && (reg_addr == PAGE_REG);
  wire key_m   = reg_wdata == MASS_KEY;
  wire key_p   = reg_wdata == PAGE_KEY;
  wire go_mass = trig_wr && key_m && arm_q && dbg_en;
  wire go_page = trig_wr && key_p && pg_arm_q;
  wire junk    = trig_wr && !key_m && !key_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q    <= 1'b0;
      pg_arm_q <= 1'b0;
      rte_q    <= 1'b0;
      busy_q   <= 1'b0;
      mass_q   <= 1'b0;
      page_q   <= 1'b0;
      pg_q     <= '0;
    end else begin
      mass_q <= go_mass;
      page_q <= go_page;

      if (ctrl_wr) begin
        arm_q <= reg_wdata[ARM_BIT];
        rte_q <= reg_wdata[RTE_BIT];
      end else if (go_mass || junk) begin
        arm_q <= 1'b0;
      end

      if (page_wr) begin
        pg_q     <= reg_wdata[DW-1:1];
        pg_arm_q <= 1'b1;
      end else if (go_page) begin
        pg_arm_q <= 1'b0;
      end

      if (go_mass || go_page) busy_q <= 1'b1;
      else if (flash_done)    busy_q <= 1'b0;
    end
  end

  assign mass_erase_o     = mass_q;
  assign page_erase_o     = page_q;
  assign page_addr_o      = pg_q;
  assign store_to_flash_o = rte_q;
  assign busy_o           = busy_q;

endmodule

module flash_erase_guard_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] ERASE_REG = 8'h94,
  parameter logic [AW-1:0] CTRL_REG  = 8'hB2,
  parameter logic [AW-1:0] PAGE_REG  = 8'hB7,
  parameter logic [DW-1:0] MASS_KEY  = 8'hAA,
  parameter logic [DW-1:0] PAGE_KEY  = 8'h55
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          dbg_en,
  input logic          flash_done,
  input logic          mass_erase_o,
  input logic          page_erase_o,
  input logic [DW-2:0] page_addr_o,
  input logic          store_to_flash_o,
  input logic          busy_o
);

  a_r9_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mass_erase_o, page_erase_o}));

  a_r3_mass_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_o |-> $past(reg_we && reg_addr == ERASE_REG && reg_wdata == MASS_KEY && dbg_en));

  a_r5_page_cause: assert property (@(posedge clk) disable iff (!rst_n)
    page_erase_o |-> $past(reg_we && reg_addr == ERASE_REG && reg_wdata == PAGE_KEY));

  a_r8_busy_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (mass_erase_o || page_erase_o) |-> busy_o);

  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !flash_done) |=> busy_o);

  a_r8_no_cmd_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !(mass_erase_o || page_erase_o));

  a_r2_route_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == CTRL_REG) |=> $stable(store_to_flash_o));

  a_r5_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == PAGE_REG) |=> $stable(page_addr_o));

endmodule

bind flash_erase_guard flash_erase_guard_chk #(
  .AW(AW), .DW(DW), .ERASE_REG(ERASE_REG), .CTRL_REG(CTRL_REG),
  .PAGE_REG(PAGE_REG), .MASS_KEY(MASS_KEY), .PAGE_KEY(PAGE_KEY)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dbg_en(dbg_en), .flash_done(flash_done),
  .mass_erase_o(mass_erase_o), .page_erase_o(page_erase_o),
  .page_addr_o(page_addr_o), .store_to_flash_o(store_to_flash_o),
  .busy_o(busy_o)
);

// File: tb/flash_erase_guard_tb_top.sv
module flash_erase_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       dbg_en = 1'b0;
  logic       flash_done = 1'b0;
  logic       mass_erase_o, page_erase_o, store_to_flash_o, busy_o;
  logic [6:0] page_addr_o;
  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  always #4 clk = ~clk;

  flash_erase_guard dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dbg_en(dbg_en), .flash_done(flash_done),
    .mass_erase_o(mass_erase_o), .page_erase_o(page_erase_o),
    .page_addr_o(page_addr_o), .store_to_flash_o(store_to_flash_o),
    .busy_o(busy_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; reg_we = 1'b0; flash_done = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // write spans one posedge; on return outputs show the result of the write
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic finish_erase();
    flash_done = 1'b1;
    @(negedge clk);
    flash_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 mass", mass_erase_o, 0);
    chk("R1 page", page_erase_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 route", store_to_flash_o, 0);
    chk("R1 paddr", page_addr_o, 0);

    for (int me = 0; me < 2; me++)
      for (int dg = 0; dg < 2; dg++)
        for (int pa = 0; pa < 2; pa++)
          for (int v = 0; v < 256; v++) begin
            logic [7:0] vb;
            logic [6:0] pg;
            bit em, ep, me_after;
            vb = v[7:0];
            pg = vb[7:1] ^ 7'h2A;
            do_reset();
            dbg_en = dg[0];
            wr(8'hB2, {6'b0, me[0], vb[0]});
            chk("R2 route", store_to_flash_o, vb[0]);
            if (pa != 0) begin
              wr(8'hB7, {pg, 1'b1});
              chk("R5 paddr", page_addr_o, pg);
            end
            em = (vb == 8'hAA) && me != 0 && dg != 0;
            ep = (vb == 8'h55) && pa != 0;
            me_after = me != 0 && !em && (vb == 8'hAA || vb == 8'h55);
            wr(8'h94, vb);
            chk("R3/R4 mass cmd", mass_erase_o, em);
            chk("R5 page cmd", page_erase_o, ep);
            chk("R8 busy", busy_o, em || ep);
            if (em || ep) begin
              @(negedge clk);
              chk("R9 pulse width", mass_erase_o | page_erase_o, 0);
              finish_erase();
              chk("R8 busy clear", busy_o, 0);
            end
            // probe arm flag: R6 disarm, R7 self-clear, R4 retain
            dbg_en = 1'b1;
            wr(8'h94, 8'hAA);
            chk("R6/R7 arm probe", mass_erase_o, me_after);
            if (me_after) finish_erase();
          end

    // R8 writes ignored while busy, arm retained
    do_reset();
    dbg_en = 1'b1;
    wr(8'hB2, 8'h02);
    wr(8'hB7, 8'h10);
    wr(8'h94, 8'h55);
    chk("R5 page start", page_erase_o, 1);
    repeat (5) @(negedge clk);
    chk("R8 busy held", busy_o, 1);
    wr(8'h94, 8'h00);
    wr(8'h94, 8'hAA);
    chk("R8 ignored mass", mass_erase_o, 0);
    chk("R8 still busy", busy_o, 1);
    finish_erase();
    chk("R8 clear", busy_o, 0);
    wr(8'h94, 8'hAA);
    chk("R8 arm kept", mass_erase_o, 1);
    finish_erase();
    wr(8'h94, 8'h55);
    chk("R7 page disarmed", page_erase_o, 0);

    // R10 other addresses
    do_reset();
    dbg_en = 1'b1;
    wr(8'hB2, 8'h03);
    wr(8'h95, 8'hAA);
    wr(8'hB3, 8'h00);
    wr(8'h93, 8'h00);
    chk("R10 no cmd", mass_erase_o, 0);
    chk("R10 route kept", store_to_flash_o, 1);
    chk("R10 busy", busy_o, 0);
    wr(8'h94, 8'hAA);
    chk("R10 arm kept", mass_erase_o, 1);

    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule